// File: doc/BRIEF.md
# Instruction Breakpoint Match Unit

This block watches the instruction fetch stream and reports when a fetch address falls on one of a small bank of instruction breakpoints. Each breakpoint is a pair of 64-bit words: an address word and a control word. The control word holds a 56-bit compare mask, a four-bit per-privilege-level enable and an execute enable in its top bit. A fetch is presented with its address, the current privilege level, a mode bit and the qualifying predicate of the instruction. The block answers one cycle later with a hit flag and the index of the lowest-numbered breakpoint that matched.

Two fetch modes change the matching rule. In native mode, fetches are 16-byte bundle addresses, so the bottom four address bits never take part in the compare. In legacy mode, fetches are 32-bit byte addresses: the fetch address is zero-extended, only the low 32 bits are compared under the low 32 mask bits, and a breakpoint whose stored upper half is not zero can never match.

The breakpoint words are written and read through an indexed access port. Only software at privilege level 0 may use it; any other level gets a fault pulse, its write is dropped and its read returns zero. Decoding, fault delivery and pipeline flushing belong to other blocks.

Top module: `ibkpt_match`

## Requirements
- R1: After reset, no hit is reported, hit_idx is 0, and every address and control word reads back as zero.
- R2: An access with cfg_pl equal to 0 writes cfg_wdata into, or reads back, the word picked by cfg_idx and cfg_ctl (0 selects the address word, 1 the control word); read data appears on cfg_rdata in the cycle after the request and is 0 in any cycle not following an allowed read.
- R3: An access with cfg_pl not 0 raises cfg_fault for exactly the next cycle, leaves all breakpoint words unchanged and returns 0 on cfg_rdata.
- R4: A breakpoint whose control bit 63 (execute enable) is 0 never matches.
- R5: Control bits 59:56 enable matching per privilege level, bit 56+L enabling level L; with the bit for fetch_pl clear the breakpoint does not match.
- R6: In native mode (legacy_mode=0), control mask bit k (55:0) set to 1 makes address bit k compared; address bits 63:56 are always compared; address bits 3:0 are never compared.
- R7: In legacy mode (legacy_mode=1), fetch_addr bits 63:32 and mask bits 55:32 are ignored, and address bits 31:0 (including 3:0) are compared where mask bits 31:0 are 1.
- R8: In legacy mode, a breakpoint whose stored address bits 63:32 are not all zero never matches.
- R9: qual_pred has no effect on hit or hit_idx.
- R10: hit and hit_idx reflect the fetch sampled at the previous clock edge (hit only if fetch_vld was 1); when several breakpoints match, hit_idx is the lowest index; hit_idx is 0 when hit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| fetch_vld | input | 1 | A fetch address is presented |
| fetch_addr | input | 64 | Fetch or bundle address |
| fetch_pl | input | 2 | Current privilege level of the fetch |
| legacy_mode | input | 1 | 1 = 32-bit byte-address mode, 0 = native bundle mode |
| qual_pred | input | 1 | Qualifying predicate of the fetched instruction |
| hit | output | 1 | Registered breakpoint hit |
| hit_idx | output | IDX_W | Index of the lowest matching breakpoint |
| cfg_req | input | 1 | Indexed access request |
| cfg_wr | input | 1 | 1 = write, 0 = read |
| cfg_idx | input | IDX_W | Breakpoint index |
| cfg_ctl | input | 1 | 0 = address word, 1 = control word |
| cfg_pl | input | 2 | Privilege level of the accessor |
| cfg_wdata | input | 64 | Write data |
| cfg_rdata | output | 64 | Registered read data |
| cfg_fault | output | 1 | Privileged-operation fault pulse |

## Verification
The assertions assume a fetch and an access may arrive in the same cycle and that cfg_idx always names an existing breakpoint; the random stimulus draws indices only from the implemented range and mixes accessor levels so that faulted and allowed accesses both occur. They also take the privilege levels as full two-bit values, so the stimulus spans all four levels in both fetch and access. Fetch addresses are built by flipping a few random bits of a stored breakpoint address, which keeps hits, near misses and multi-hit priority cases all frequent.

// File: rtl/ibkpt_match.sv
module ibkpt_match #(
  parameter int NUM_BKPT = 4,
  localparam int IDX_W = (NUM_BKPT > 1) ? $clog2(NUM_BKPT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fetch_vld,
  input  logic [63:0]      fetch_addr,
  input  logic [1:0]       fetch_pl,
  input  logic             legacy_mode,
  input  logic             qual_pred,
  output logic             hit,
  output logic [IDX_W-1:0] hit_idx,
  input  logic             cfg_req,
  input  logic             cfg_wr,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic             cfg_ctl,
  input  logic [1:0]       cfg_pl,
  input  logic [63:0]      cfg_wdata,
  output logic [63:0]      cfg_rdata,
  output logic             cfg_fault
);

  logic [63:0]         addr_q [NUM_BKPT];
  logic [63:0]         ctl_q  [NUM_BKPT];
  logic [NUM_BKPT-1:0] match_vec;
  logic [NUM_BKPT-1:0] en_vec;
  logic [IDX_W-1:0]    first_idx;

  wire priv_ok = (cfg_pl == 2'd0);
  wire idx_ok  = (int'(cfg_idx) < NUM_BKPT);
  wire acc_ok  = cfg_req && priv_ok && idx_ok;
  wire unused_pred = qual_pred;

  for (genvar g = 0; g < NUM_BKPT; g++) begin : g_bk
    logic [63:0] care;
    logic        addr_eq;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        addr_q[g] <= '0;
        ctl_q[g]  <= '0;
      end else if (acc_ok && cfg_wr && int'(cfg_idx) == g) begin
        if (cfg_ctl) ctl_q[g]  <= cfg_wdata;
        else         addr_q[g] <= cfg_wdata;
      end
    end

    always_comb begin
      if (legacy_mode) begin
        care    = {32'h0, ctl_q[g][31:0]};
        addr_eq = (addr_q[g][63:32] == 32'h0) &&
                  ((({32'h0, fetch_addr[31:0]} ^ addr_q[g]) & care) == 64'h0);
      end else begin
        care    = {8'hFF, ctl_q[g][55:4], 4'h0};
        addr_eq = ((fetch_addr ^ addr_q[g]) & care) == 64'h0;
      end
    end

    assign en_vec[g]    = ctl_q[g][63];
    assign match_vec[g] = en_vec[g] && ctl_q[g][56 + fetch_pl] && addr_eq;

    assert_no_write_when_denied_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_req && cfg_wr && !priv_ok) |=> ($stable(addr_q[g]) && $stable(ctl_q[g])));
  end

  always_comb begin
    first_idx = '0;
    for (int i = NUM_BKPT - 1; i >= 0; i--)
      if (match_vec[i]) first_idx = IDX_W'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit       <= 1'b0;
      hit_idx   <= '0;
      cfg_rdata <= '0;
      cfg_fault <= 1'b0;
    end else begin
      hit       <= fetch_vld && (|match_vec);
      hit_idx   <= (fetch_vld && (|match_vec)) ? first_idx : '0;
      cfg_fault <= cfg_req && !priv_ok;
      cfg_rdata <= (acc_ok && !cfg_wr) ?
                   (cfg_ctl ? ctl_q[cfg_idx] : addr_q[cfg_idx]) : 64'h0;
    end
  end

  assert_fault_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && cfg_pl != 2'd0) |=> cfg_fault);

  assert_fault_no_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_fault |-> (cfg_rdata == 64'h0));

  assert_all_disabled_no_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_vec == '0) |=> !hit);

  assert_no_fetch_no_hit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_vld |=> (!hit && hit_idx == '0));

endmodule

// File: tb/ibkpt_match_tb_top.sv
module ibkpt_match_tb_top;
  localparam int NB = 4;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fetch_vld = 1'b0, legacy_mode = 1'b0, qual_pred = 1'b0;
  logic [63:0] fetch_addr = '0;
  logic [1:0] fetch_pl = '0;
  logic hit;
  logic [IW-1:0] hit_idx;
  logic cfg_req = 1'b0, cfg_wr = 1'b0, cfg_ctl = 1'b0;
  logic [IW-1:0] cfg_idx = '0;
  logic [1:0] cfg_pl = '0;
  logic [63:0] cfg_wdata = '0;
  logic [63:0] cfg_rdata;
  logic cfg_fault;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [63:0] ma [NB];
  logic [63:0] mc [NB];

  always #5 clk = ~clk;

  ibkpt_match #(.NUM_BKPT(NB)) dut_i (
    .clk, .rst_n, .fetch_vld, .fetch_addr, .fetch_pl, .legacy_mode, .qual_pred,
    .hit, .hit_idx, .cfg_req, .cfg_wr, .cfg_idx, .cfg_ctl, .cfg_pl,
    .cfg_wdata, .cfg_rdata, .cfg_fault);

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit ref_match(int j, logic [63:0] fa, logic [1:0] pl, bit leg);
    logic [63:0] cmp;
    if (!mc[j][63]) return 0;
    if (!mc[j][56 + pl]) return 0;
    if (leg) begin
      if (ma[j][63:32] != 0) return 0;
      return ((fa[31:0] ^ ma[j][31:0]) & mc[j][31:0]) == 0;
    end
    cmp = {8'hFF, mc[j][55:0]};
    cmp[3:0] = 4'h0;
    return ((fa ^ ma[j]) & cmp) == 0;
  endfunction

  task automatic access(bit wr, int idx, bit ctl, logic [1:0] pl, logic [63:0] wd, string req);
    @(negedge clk);
    cfg_req = 1; cfg_wr = wr; cfg_idx = IW'(idx); cfg_ctl = ctl; cfg_pl = pl; cfg_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    cfg_req = 0; cfg_wr = 0;
    check({req, " fault"}, 64'(cfg_fault), 64'(pl != 0));
    if (!wr) check({req, " rdata"}, cfg_rdata, (pl != 0) ? 64'h0 : (ctl ? mc[idx] : ma[idx]));
    else if (pl == 0) begin
      if (ctl) mc[idx] = wd; else ma[idx] = wd;
    end
  endtask

  task automatic fetch(logic [63:0] fa, logic [1:0] pl, bit leg, bit pred, bit vld, string req);
    bit eh = 0;
    logic [IW-1:0] ei = '0;
    for (int j = NB - 1; j >= 0; j--)
      if (vld && ref_match(j, fa, pl, leg)) begin eh = 1; ei = IW'(j); end
    @(negedge clk);
    fetch_vld = vld; fetch_addr = fa; fetch_pl = pl; legacy_mode = leg; qual_pred = pred;
    @(posedge clk);
    @(negedge clk);
    fetch_vld = 0;
    check({req, " hit"}, 64'(hit), 64'(eh));
    check({req, " idx"}, 64'(hit_idx), 64'(ei));
  endtask

  function automatic logic [63:0] r64();
    return {$urandom, $urandom};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    for (int j = 0; j < NB; j++) begin ma[j] = '0; mc[j] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset hit", 64'(hit), 0);
    check("R1 reset idx", 64'(hit_idx), 0);
    rst_n = 1;
    for (int j = 0; j < NB; j++) begin
      access(0, j, 0, 0, 0, "R1 reset addr");
      access(0, j, 1, 0, 0, "R1 reset ctl");
    end

    access(1, 0, 0, 0, 64'h1234_5678_9ABC_DEF0, "R2 wr");
    access(1, 0, 1, 0, {1'b1, 3'b0, 4'b0001, {56{1'b1}}}, "R2 wr");
    access(1, 1, 0, 0, 64'h1234_5678_9ABC_DEF0, "R2 wr");
    access(1, 1, 1, 0, {1'b1, 3'b0, 4'b1111, {56{1'b1}}}, "R2 wr");
    access(0, 0, 0, 0, 0, "R2 rd addr");
    access(0, 1, 1, 0, 0, "R2 rd ctl");

    access(1, 0, 0, 2, 64'hDEAD, "R3 denied wr");
    access(0, 0, 0, 0, 0, "R3 unchanged");
    access(0, 1, 1, 3, 0, "R3 denied rd");

    fetch(64'h1234_5678_9ABC_DEF7, 0, 0, 1, 1, "R6/R10 low bits ignored, lowest");
    fetch(64'h1234_5678_9ABC_DEF0, 0, 0, 1, 0, "R10 no valid");
    fetch(64'h1234_5678_9ABC_DEF0, 1, 0, 1, 1, "R5 plm level1");
    fetch(64'h1234_5678_9ABC_DEF0, 0, 0, 0, 1, "R9 false pred");
    fetch(64'h0234_5678_9ABC_DEF0, 0, 0, 1, 1, "R6 upper compared");
    access(1, 1, 1, 0, {1'b0, 3'b0, 4'b1111, {56{1'b1}}}, "R4 wr");
    fetch(64'h1234_5678_9ABC_DEF0, 1, 0, 1, 1, "R4 disabled");

    access(1, 2, 0, 0, 64'h0000_0000_0000_1000, "R7 wr");
    access(1, 2, 1, 0, {1'b1, 3'b0, 4'b1111, {56{1'b1}}}, "R7 wr");
    fetch(64'hABCD_0000_0000_1000, 3, 1, 1, 1, "R7 upper fetch ignored");
    fetch(64'hABCD_0000_0000_1000, 3, 0, 1, 1, "R6 native upper compared");
    fetch(64'h0000_0000_0000_1001, 3, 1, 1, 1, "R7 low bits compared");
    access(1, 2, 1, 0, 64'h0, "R8 wr");
    access(1, 3, 0, 0, 64'h0000_0001_0000_1000, "R8 wr");
    access(1, 3, 1, 0, {1'b1, 3'b0, 4'b1111, {56{1'b1}}}, "R8 wr");
    fetch(64'h0000_0000_0000_1000, 0, 1, 1, 1, "R8 upper stored nonzero");

    for (int n = 0; n < 400; n++) begin
      int sel = $urandom_range(0, 9);
      int j = $urandom_range(0, NB - 1);
      if (sel == 0) begin
        logic [63:0] a = r64();
        if ($urandom_range(0, 1)) a[63:32] = 0;
        access(1, j, 0, 2'($urandom_range(0, 3) == 0 ? 1 : 0), a, "R2 rand wr");
      end else if (sel == 1) begin
        logic [63:0] c = r64();
        c[55:0] = c[55:0] | r64()[55:0];
        c[63] = ($urandom_range(0, 3) != 0);
        access(1, j, 1, 2'($urandom_range(0, 3) == 0 ? 2 : 0), c, "R2 rand wr");
      end else if (sel == 2) begin
        access(0, j, 1'($urandom), 2'($urandom_range(0, 3)), 0, "R3 rand rd");
      end else begin
        logic [63:0] fa = ma[j] ^ (r64() & r64() & r64() & r64());
        bit leg = 1'($urandom);
        if (leg && $urandom_range(0, 1)) fa[63:32] = r64()[31:0];
        fetch(fa, 2'($urandom), leg, 1'($urandom), ($urandom_range(0, 7) != 0), "R10 rand fetch");
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule